// File: doc/BRIEF.md
# Dual-Output Gate Drive Slew Sequencer

This block is the digital control core of a single-channel gate driver whose power stage has two outputs, a main output and an auxiliary output, each tied to its own gate resistor. The main output copies a PWM command. An active-low select input chooses, edge by edge, whether the auxiliary output switches in parallel with the main output, which gives a faster gate transition, or floats, which leaves the slower path alone. The select level used for an edge is frozen for a hold window after that edge. After any supply fault the select falls back to "auxiliary enabled" until a new select edge arrives.

A parameter picks one of two variants. In the standard variant an enabled auxiliary output follows both PWM edges. In the turn-on-only variant the auxiliary output helps only on rising edges and floats at every falling edge. Input-side and output-side supply-good flags gate all activity. High impedance is shown by a deasserted auxiliary enable, and the drive level is then forced low. All inputs are synchronous. All outputs are registered, so they react one clock after the inputs.

Top module: `gate_slew_seq`

## Requirements
- R1: While both supplies are good and were good in the previous cycle, `drv_main_o` equals the `pwm_i` value of the previous cycle.
- R2: On a PWM edge with effective select 0, the auxiliary output is enabled and driven to the new PWM level. With effective select 1, `aux_en_o` becomes 0.
- R3: In the standard variant (TURN_ON_ONLY=0), an enabled auxiliary output is driven low on a falling PWM edge.
- R4: In the turn-on-only variant (TURN_ON_ONLY=1), every falling PWM edge deasserts `aux_en_o`. A rising edge with select 0 enables it and drives it high.
- R5: A change of `sel_n_i` while `pwm_i` is steady changes no output.
- R6: A select change in the same cycle as a PWM edge takes effect for that edge.
- R7: For HOLD_CYC cycles after a PWM edge, the effective select stays at the value used for that edge. A further PWM edge inside the window uses the frozen value. The first edge after the window uses the live `sel_n_i`.
- R8: After reset or after any supply fault, the effective select is 0 until a `sel_n_i` edge is seen while both supplies are good.
- R9: In the first cycle in which both supplies are good again, the main output takes the live `pwm_i`. The auxiliary output is enabled with the default select: at the PWM level in the standard variant, and only if PWM is high in the turn-on-only variant.
- R10: With only the input-side supply low, the main output goes low. In the standard variant an enabled auxiliary output is driven low and a floating one stays floating. In the turn-on-only variant the auxiliary output floats.
- R11: With the output-side supply low, the main output is low and `aux_en_o` is 0, whatever the other inputs are.
- R12: Whenever `aux_en_o` is 1, `drv_aux_o` equals `drv_main_o`.
- R13: During reset, `drv_main_o`, `drv_aux_o` and `aux_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Filtered PWM command |
| sel_n_i | input | 1 | Auxiliary select, active low (0 = parallel drive) |
| in_ok_i | input | 1 | Input-side supply good |
| out_ok_i | input | 1 | Output-side supply good |
| drv_main_o | output | 1 | Main output drive level |
| drv_aux_o | output | 1 | Auxiliary output drive level (0 when floating) |
| aux_en_o | output | 1 | Auxiliary output enable; 0 means high impedance |

## Verification
The bench builds two copies of the block with HOLD_CYC=4: one in the standard variant and one in the turn-on-only variant. Both see the same stimulus. The short window makes the inside and outside cases of the hold check reachable within a handful of cycles, including an edge on the last frozen cycle and one on the first live cycle. A pseudo-random sweep over PWM, select and both supply flags, with rare faults, drives every combination of edge, hold, arming and recovery. Both copies are compared each cycle against an arithmetic model written from the requirements.

// File: rtl/gss_pkg.sv
package gss_pkg;

   typedef enum logic [1:0] {
      SUP_OUT_LOW = 2'd0,
      SUP_IN_LOW  = 2'd1,
      SUP_RECOVER = 2'd2,
      SUP_RUN     = 2'd3
   } sup_state_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2
   } pwm_edge_e;

   function automatic pwm_edge_e classify_edge(input logic now_lvl, input logic prev_lvl);
      if (now_lvl && !prev_lvl)      return EDGE_RISE;
      else if (!now_lvl && prev_lvl) return EDGE_FALL;
      else                           return EDGE_NONE;
   endfunction

endpackage

// File: rtl/gss_front.sv
module gss_front
   import gss_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwm_i,
   input  logic       in_ok_i,
   input  logic       out_ok_i,
   output sup_state_e sup_o,
   output pwm_edge_e  edge_o
);

   logic both_ok;
   logic ok_prev_q;
   logic pwm_prev_q;

   assign both_ok = in_ok_i & out_ok_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok_prev_q  <= 1'b0;
         pwm_prev_q <= 1'b0;
      end else begin
         ok_prev_q  <= both_ok;
         pwm_prev_q <= pwm_i;
      end
   end

   always_comb begin
      if (!out_ok_i)      sup_o = SUP_OUT_LOW;
      else if (!in_ok_i)  sup_o = SUP_IN_LOW;
      else if (!ok_prev_q) sup_o = SUP_RECOVER;
      else                sup_o = SUP_RUN;
   end

   always_comb begin
      edge_o = EDGE_NONE;
      if (sup_o == SUP_RUN) edge_o = classify_edge(pwm_i, pwm_prev_q);
   end

endmodule

// File: rtl/gss_sel_track.sv
module gss_sel_track
   import gss_pkg::*;
#(
   parameter int HOLD_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  sup_state_e sup_i,
   input  pwm_edge_e  edge_i,
   input  logic       sel_n_i,
   output logic       aux_req_o
);

   localparam int            CW      = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC);

   initial begin : prm_chk
      assert (HOLD_CYC >= 1) else $error("HOLD_CYC must be at least 1");
   end

   logic          live;
   logic          sel_prev_q;
   logic          armed_q;
   logic          sel_frz_q;
   logic [CW-1:0] hold_q;
   logic          sel_edge;
   logic          armed_now;
   logic          hold_on;
   logic          sel_eff;

   assign live      = (sup_i == SUP_RUN) || (sup_i == SUP_RECOVER);
   assign sel_edge  = live && (sel_n_i != sel_prev_q);
   assign armed_now = armed_q | sel_edge;
   assign hold_on   = (hold_q != '0);
   assign sel_eff   = armed_now ? (hold_on ? sel_frz_q : sel_n_i) : 1'b0;
   assign aux_req_o = ~sel_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_prev_q <= 1'b0;
         armed_q    <= 1'b0;
         sel_frz_q  <= 1'b0;
         hold_q     <= '0;
      end else begin
         sel_prev_q <= sel_n_i;
         if (!live) begin
            armed_q   <= 1'b0;
            sel_frz_q <= 1'b0;
            hold_q    <= '0;
         end else begin
            armed_q   <= armed_now;
            sel_frz_q <= sel_eff;
            if (edge_i != EDGE_NONE) hold_q <= HOLD_LD;
            else if (hold_on)        hold_q <= hold_q - 1'b1;
         end
      end
   end

   // R8
   default_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_i == SUP_RECOVER && sel_n_i == sel_prev_q) |-> aux_req_o);

endmodule

// File: rtl/gss_out_seq.sv
module gss_out_seq
   import gss_pkg::*;
#(
   parameter bit TURN_ON_ONLY = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  sup_state_e sup_i,
   input  pwm_edge_e  edge_i,
   input  logic       pwm_i,
   input  logic       aux_req_i,
   output logic       main_o,
   output logic       aux_drv_o,
   output logic       aux_en_o
);

   logic keep_on_fall;
   logic lo_only_ok;
   logic main_q, drv_q, en_q;
   logic main_d, drv_d, en_d;

   generate
      if (TURN_ON_ONLY) begin : g_turn_on
         assign keep_on_fall = 1'b0;
         assign lo_only_ok   = 1'b0;
         // R4
         fall_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_i == EDGE_FALL) |=> !aux_en_o);
      end else begin : g_std
         assign keep_on_fall = 1'b1;
         assign lo_only_ok   = 1'b1;
      end
   endgenerate

   always_comb begin
      main_d = main_q;
      drv_d  = drv_q;
      en_d   = en_q;
      unique case (sup_i)
         SUP_OUT_LOW: begin
            main_d = 1'b0;
            drv_d  = 1'b0;
            en_d   = 1'b0;
         end
         SUP_IN_LOW: begin
            main_d = 1'b0;
            drv_d  = 1'b0;
            en_d   = en_q & lo_only_ok;
         end
         SUP_RECOVER: begin
            main_d = pwm_i;
            drv_d  = pwm_i;
            en_d   = aux_req_i & (pwm_i | keep_on_fall);
         end
         SUP_RUN: begin
            if (edge_i == EDGE_RISE) begin
               main_d = 1'b1;
               drv_d  = 1'b1;
               en_d   = aux_req_i;
            end else if (edge_i == EDGE_FALL) begin
               main_d = 1'b0;
               drv_d  = 1'b0;
               en_d   = aux_req_i & keep_on_fall;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_q <= 1'b0;
         drv_q  <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         main_q <= main_d;
         drv_q  <= drv_d;
         en_q   <= en_d;
      end
   end

   assign main_o    = main_q;
   assign aux_en_o  = en_q;
   assign aux_drv_o = en_q & drv_q;

   // R12
   no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aux_en_o |-> (aux_drv_o == main_o));

endmodule

// File: rtl/gate_slew_seq.sv
module gate_slew_seq
   import gss_pkg::*;
#(
   parameter int HOLD_CYC     = 4,
   parameter bit TURN_ON_ONLY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_i,
   input  logic sel_n_i,
   input  logic in_ok_i,
   input  logic out_ok_i,
   output logic drv_main_o,
   output logic drv_aux_o,
   output logic aux_en_o
);

   sup_state_e sup;
   pwm_edge_e  pwm_edge;
   logic       aux_req;

   gss_front u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_i    (pwm_i),
      .in_ok_i  (in_ok_i),
      .out_ok_i (out_ok_i),
      .sup_o    (sup),
      .edge_o   (pwm_edge)
   );

   gss_sel_track #(.HOLD_CYC(HOLD_CYC)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .sup_i     (sup),
      .edge_i    (pwm_edge),
      .sel_n_i   (sel_n_i),
      .aux_req_o (aux_req)
   );

   gss_out_seq #(.TURN_ON_ONLY(TURN_ON_ONLY)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .sup_i     (sup),
      .edge_i    (pwm_edge),
      .pwm_i     (pwm_i),
      .aux_req_i (aux_req),
      .main_o    (drv_main_o),
      .aux_drv_o (drv_aux_o),
      .aux_en_o  (aux_en_o)
   );

   // R1
   main_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sup == SUP_RUN) |=> (drv_main_o == $past(pwm_i)));

   // R5
   steady_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sup == SUP_RUN && pwm_edge == EDGE_NONE) |=>
         (drv_main_o == $past(drv_main_o) && aux_en_o == $past(aux_en_o)
          && drv_aux_o == $past(drv_aux_o)));

   // R11
   out_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ok_i |=> (!drv_main_o && !aux_en_o));

endmodule

// File: tb/gate_slew_seq_tb.sv
`timescale 1ns/1ps
module gate_slew_seq_tb;

   localparam int HOLD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm = 1'b0, sel_n = 1'b0, iok = 1'b0, ook = 1'b0;
   logic main_s, auxd_s, auxe_s;
   logic main_t, auxd_t, auxe_t;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   gate_slew_seq #(.HOLD_CYC(HOLD), .TURN_ON_ONLY(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .sel_n_i(sel_n),
      .in_ok_i(iok), .out_ok_i(ook),
      .drv_main_o(main_s), .drv_aux_o(auxd_s), .aux_en_o(auxe_s));

   gate_slew_seq #(.HOLD_CYC(HOLD), .TURN_ON_ONLY(1'b1)) u_dut_t (
      .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .sel_n_i(sel_n),
      .in_ok_i(iok), .out_ok_i(ook),
      .drv_main_o(main_t), .drv_aux_o(auxd_t), .aux_en_o(auxe_t));

   // reference model state
   bit m_main, m_en_s, m_drv_s, m_en_t, m_drv_t;
   bit m_okp, m_pwmp, m_selp, m_armed, m_selq;
   int m_cnt;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic mdl(input bit p, input bit s, input bit i, input bit o);
      bit ok, edg, sedge, anow, hold, seff, req;
      ok    = i & o;
      edg   = m_okp & ok & (p != m_pwmp);
      sedge = ok & (s != m_selp);
      anow  = m_armed | sedge;
      hold  = (m_cnt != 0);
      seff  = anow ? (hold ? m_selq : s) : 1'b0;
      req   = !seff;
      if (!o) begin
         m_main = 0; m_en_s = 0; m_drv_s = 0; m_en_t = 0; m_drv_t = 0;
      end else if (!i) begin
         m_main = 0; m_drv_s = 0; m_en_t = 0; m_drv_t = 0;
      end else if (!m_okp) begin
         m_main = p; m_en_s = req; m_drv_s = p; m_en_t = req & p; m_drv_t = p;
      end else if (edg) begin
         m_main = p; m_drv_s = p; m_drv_t = p;
         m_en_s = req; m_en_t = p ? req : 1'b0;
      end
      m_armed = ok ? anow : 1'b0;
      m_selq  = ok ? seff : 1'b0;
      if (!ok)       m_cnt = 0;
      else if (edg)  m_cnt = HOLD;
      else if (hold) m_cnt = m_cnt - 1;
      m_okp = ok; m_pwmp = p; m_selp = s;
   endtask

   task automatic cmp(input string req);
      chk(main_s == m_main, req, main_s, m_main);
      chk(auxe_s == m_en_s && (!m_en_s || auxd_s == m_drv_s), req,
          {auxe_s, auxd_s}, {m_en_s, m_drv_s});
      chk(main_t == m_main, req, main_t, m_main);
      chk(auxe_t == m_en_t && (!m_en_t || auxd_t == m_drv_t), req,
          {auxe_t, auxd_t}, {m_en_t, m_drv_t});
      // R12 at the ports
      chk(!auxe_s || auxd_s == main_s, "R12", auxd_s, main_s);
      chk(!auxe_t || auxd_t == main_t, "R12", auxd_t, main_t);
   endtask

   task automatic step(input bit p, input bit s, input bit i, input bit o, input string req);
      pwm = p; sel_n = s; iok = i; ook = o;
      mdl(p, s, i, o);
      @(posedge clk); #2;
      cmp(req);
   endtask

   initial begin : wdog
      #(200000 * 8);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main_seq
      bit [15:0] lfsr;
      repeat (3) @(posedge clk);
      #2;
      // R13
      chk(main_s == 0 && auxe_s == 0 && auxd_s == 0, "R13", {main_s, auxe_s, auxd_s}, 0);
      chk(main_t == 0 && auxe_t == 0 && auxd_t == 0, "R13", {main_t, auxe_t, auxd_t}, 0);
      rst_n = 1'b1;
      step(0, 1, 0, 0, "R11");
      step(0, 1, 0, 0, "R11");

      // recovery with pwm low, select held high: default enabled
      step(0, 1, 1, 1, "R9");
      chk(auxe_s == 1 && auxe_t == 0 && main_s == 0, "R9", {auxe_s, auxe_t}, 2);
      step(1, 1, 1, 1, "R8");
      chk(auxe_s == 1 && auxd_s == 1 && auxe_t == 1 && main_s == 1, "R8", {auxe_s, auxd_s}, 3);
      repeat (5) step(1, 1, 1, 1, "R1");
      // select changes while pwm steady
      step(1, 0, 1, 1, "R5");
      repeat (5) step(1, 0, 1, 1, "R5");
      step(1, 1, 1, 1, "R5");
      chk(auxe_s == 1 && auxd_s == 1, "R5", auxe_s, 1);
      repeat (5) step(1, 1, 1, 1, "R5");
      // falling edge with select high: both float
      step(0, 1, 1, 1, "R2");
      chk(auxe_s == 0 && auxe_t == 0 && main_s == 0, "R2", {auxe_s, auxe_t}, 0);
      repeat (5) step(0, 1, 1, 1, "R1");
      // select low in the same cycle as a rising edge
      step(1, 0, 1, 1, "R6");
      chk(auxe_s == 1 && auxd_s == 1 && auxe_t == 1 && auxd_t == 1, "R6", {auxe_s, auxe_t}, 3);
      // select goes high inside the window; edges on last frozen and first live cycles
      step(1, 1, 1, 1, "R7");
      step(1, 1, 1, 1, "R7");
      step(1, 1, 1, 1, "R7");
      step(0, 1, 1, 1, "R7");
      chk(auxe_s == 1 && auxd_s == 0, "R3", {auxe_s, auxd_s}, 2);
      chk(auxe_t == 0, "R4", auxe_t, 0);
      step(0, 1, 1, 1, "R7");
      step(0, 1, 1, 1, "R7");
      step(0, 1, 1, 1, "R7");
      step(1, 1, 1, 1, "R7");
      chk(auxe_s == 1 && auxe_t == 1, "R7", {auxe_s, auxe_t}, 3);
      step(1, 1, 1, 1, "R7");
      step(1, 1, 1, 1, "R7");
      step(1, 1, 1, 1, "R7");
      step(1, 1, 1, 1, "R7");
      step(0, 1, 1, 1, "R7");
      chk(auxe_s == 0 && auxe_t == 0, "R7", {auxe_s, auxe_t}, 0);
      repeat (5) step(0, 1, 1, 1, "R1");
      // enabled and high, then input-side fault
      step(0, 0, 1, 1, "R5");
      repeat (5) step(0, 0, 1, 1, "R5");
      step(1, 0, 1, 1, "R2");
      repeat (5) step(1, 0, 1, 1, "R1");
      step(1, 0, 0, 1, "R10");
      chk(main_s == 0 && auxe_s == 1 && auxd_s == 0 && auxe_t == 0, "R10",
          {main_s, auxe_s, auxd_s, auxe_t}, 4);
      step(1, 1, 0, 1, "R10");
      // recovery with select high but no fresh edge
      step(1, 1, 1, 1, "R9");
      chk(main_s == 1 && auxe_s == 1 && auxd_s == 1 && auxe_t == 1, "R9", {main_s, auxe_s}, 3);
      repeat (5) step(1, 1, 1, 1, "R1");
      step(0, 1, 1, 1, "R8");
      chk(auxe_s == 1 && auxd_s == 0, "R8", {auxe_s, auxd_s}, 2);
      // floating aux stays floating through an input fault
      step(0, 0, 1, 1, "R5");
      repeat (5) step(0, 0, 1, 1, "R5");
      step(0, 1, 1, 1, "R5");
      repeat (5) step(0, 1, 1, 1, "R5");
      step(1, 1, 1, 1, "R2");
      chk(auxe_s == 0, "R2", auxe_s, 0);
      step(1, 1, 0, 1, "R10");
      chk(auxe_s == 0 && main_s == 0, "R10", {auxe_s, main_s}, 0);
      step(1, 0, 1, 1, "R9");
      repeat (5) step(1, 0, 1, 1, "R1");
      // output-side fault with input side good
      step(1, 0, 1, 0, "R11");
      chk(main_s == 0 && auxe_s == 0 && main_t == 0 && auxe_t == 0, "R11",
          {main_s, auxe_s, main_t, auxe_t}, 0);
      step(0, 1, 1, 0, "R11");

      // pseudo-random sweep against the model
      lfsr = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
         bit p, s, i, o;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         p = lfsr[0] ^ lfsr[7];
         s = lfsr[3] & lfsr[9];
         i = (lfsr[15:11] != 5'd0);
         o = (lfsr[10:6] != 5'd3);
         step(p, s, i, o, "R1");
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule